// File: doc/BRIEF.md
# Debug Message Byte FIFO

This block is a bus-slave peripheral that carries a stream of bytes from embedded firmware to an external debug host, giving firmware a simple text output path. Firmware pushes bytes by storing them to a data-in register. The host polls a status word and takes bytes by loading from a data-out register. The queue is driven entirely through the side effects of register accesses: a store to the data-in offset enqueues, and a load of the data-out offset dequeues.

The register window is reached through two identical synchronous access ports. One port is for the device and one is for the host, and both decode the same three word-spaced offsets. A request is valid for exactly the cycle in which its select is high. There is no ready signal, so the block never applies back-pressure. A byte written while the queue is full is dropped instead of stalling the writer, and a load of an empty queue returns zero. Each load answers on the next cycle with a one-cycle response strobe.

The queue depth is a power-of-two parameter. The read and write pointers carry one extra wrap bit, so a full queue and an empty queue can be told apart without a separate counter.

Top module: `dbg_msg_fifo`

## Requirements
- R1: After a synchronous active-high reset, both response strobes are low and a status load returns 0x00.
- R2: Offset 0x0 is the data-in register, 0x4 is data-out and 0x8 is status, decoded on all ADDR_W address bits. Each load, at any offset, raises that port's response strobe for exactly the following cycle with the data. A store raises no strobe.
- R3: A store to data-in while the queue is not full enqueues the low byte. Loads of data-out return the stored bytes in the order they were written, and either port may push or pop.
- R4: Status bit 0 is 1 exactly when DEPTH bytes are held, bit 1 is 1 exactly when at least one byte is held, and bits 7:2 read 0. The flags reflect every push and pop from the clock edge that performs it.
- R5: A store to data-in while the queue is full is dropped, and the stored bytes and the write pointer are left unchanged.
- R6: A load of data-out while the queue is empty returns 0x00 and does not move the read pointer.
- R7: A push on one port and a pop on the other in the same cycle leave the occupancy unchanged. When the queue is empty in that cycle, the pop returns 0x00 and the push is kept. When the queue is full, the pop is served and the push is dropped.
- R8: When both ports push in the same cycle, only the device port's byte is kept. When both ports load data-out in the same cycle, the device port receives the head byte and the host port receives 0x00 without a second pop.
- R9: Loads of data-in and of unmapped offsets return 0x00. Stores to data-out, to status and to unmapped offsets change nothing.
- R10: Asserting reset while bytes are held empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 1 | Device port request valid |
| dev_we | input | 1 | Device port request is a store (1) or a load (0) |
| dev_addr | input | ADDR_W | Device port byte offset |
| dev_wdata | input | 8 | Device port store data |
| dev_rvalid | output | 1 | Device port load response strobe |
| dev_rdata | output | 8 | Device port load response data |
| host_sel | input | 1 | Host port request valid |
| host_we | input | 1 | Host port request is a store (1) or a load (0) |
| host_addr | input | ADDR_W | Host port byte offset |
| host_wdata | input | 8 | Host port store data |
| host_rvalid | output | 1 | Host port load response strobe |
| host_rdata | output | 8 | Host port load response data |

## Verification
The functions that can fall into one cycle are a push from one port and a pop from the other. The bench provokes this by driving a device store to data-in and a host load of data-out on the same clock edge. It does so with one byte held, with the queue empty and with the queue full. Each case is judged by the popped value and by a status load afterwards. A final drain then confirms which pushed byte survived.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  localparam int unsigned BYTE_W = 8;

  // Word-spaced register offsets (decoded on the full address width).
  localparam int unsigned OFF_IN   = 'h0;
  localparam int unsigned OFF_OUT  = 'h4;
  localparam int unsigned OFF_STAT = 'h8;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_IN,
    TGT_OUT,
    TGT_STAT
  } tgt_e;

  typedef struct packed {
    logic have;
    logic full;
  } flags_t;

  // Status byte: bit 0 full, bit 1 have, upper bits zero.
  function automatic logic [BYTE_W-1:0] pack_status(input flags_t f);
    return BYTE_W'({f.have, f.full});
  endfunction

endpackage

// File: rtl/dmf_decode.sv
module dmf_decode
  import dmf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd,
  output logic              push,
  output logic              pop,
  output tgt_e              tgt
);

  tgt_e hit;

  always_comb begin
    if (addr == ADDR_W'(OFF_IN))        hit = TGT_IN;
    else if (addr == ADDR_W'(OFF_OUT))  hit = TGT_OUT;
    else if (addr == ADDR_W'(OFF_STAT)) hit = TGT_STAT;
    else                                hit = TGT_NONE;
  end

  assign tgt  = sel ? hit : TGT_NONE;
  assign rd   = sel & ~we;
  assign push = sel & we & (hit == TGT_IN);
  assign pop  = sel & ~we & (hit == TGT_OUT);

endmodule

// File: rtl/dmf_arbiter.sv
module dmf_arbiter
  import dmf_pkg::*;
#(
  parameter int unsigned PORTS = 2
) (
  input  logic [PORTS-1:0]  push_req,
  input  logic [PORTS-1:0]  pop_req,
  input  logic [BYTE_W-1:0] wdata [PORTS],
  input  logic              full,
  input  logic              empty,
  output logic              push_ok,
  output logic [BYTE_W-1:0] push_data,
  output logic              pop_ok,
  output logic [PORTS-1:0]  pop_grant
);

  // Lowest index wins each contest; flags are the pre-edge state.
  always_comb begin
    push_ok   = 1'b0;
    push_data = '0;
    pop_grant = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (push_req[p] && !push_ok && !full) begin
        push_ok   = 1'b1;
        push_data = wdata[p];
      end
      if (pop_req[p] && (pop_grant == '0) && !empty) begin
        pop_grant[p] = 1'b1;
      end
    end
    pop_ok = |pop_grant;
  end

endmodule

// File: rtl/dmf_ptrs.sv
module dmf_ptrs #(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_ok,
  input  logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [IDX_W-1:0] waddr,
  output logic [IDX_W-1:0] raddr,
  output logic             full,
  output logic             empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end

  assign waddr = wr_ptr[IDX_W-1:0];
  assign raddr = rd_ptr[IDX_W-1:0];
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[IDX_W] != rd_ptr[IDX_W]) &&
                 (wr_ptr[IDX_W-1:0] == rd_ptr[IDX_W-1:0]);

endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned W     = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dmf_resp.sv
module dmf_resp
  import dmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  tgt_e              tgt,
  input  logic              grant,
  input  logic [BYTE_W-1:0] head,
  input  flags_t            flags,
  output logic              rvalid,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (rd) begin
      case (tgt)
        TGT_OUT:  nxt = grant ? head : '0;
        TGT_STAT: nxt = pack_status(flags);
        default:  nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= nxt;
    end
  end

endmodule

// File: rtl/dbg_msg_fifo.sv
module dbg_msg_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_sel,
  input  logic              dev_we,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [7:0]        dev_wdata,
  output logic              dev_rvalid,
  output logic [7:0]        dev_rdata,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              host_rvalid,
  output logic [7:0]        host_rdata
);

  localparam int unsigned PORTS     = 2;
  localparam int unsigned DEV_PORT  = 0;
  localparam int unsigned HOST_PORT = 1;
  localparam int unsigned IDX_W     = $clog2(DEPTH);
  localparam int unsigned PTR_W     = IDX_W + 1;

  logic              p_sel    [PORTS];
  logic              p_we     [PORTS];
  logic [ADDR_W-1:0] p_addr   [PORTS];
  logic [BYTE_W-1:0] p_wdata  [PORTS];
  logic              p_rvalid [PORTS];
  logic [BYTE_W-1:0] p_rdata  [PORTS];
  logic              p_rd     [PORTS];
  tgt_e              p_tgt    [PORTS];
  logic [PORTS-1:0]  push_req;
  logic [PORTS-1:0]  pop_req;
  logic [PORTS-1:0]  pop_grant;

  logic              push_ok;
  logic              pop_ok;
  logic [BYTE_W-1:0] push_data;
  logic [BYTE_W-1:0] head;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [IDX_W-1:0]  waddr;
  logic [IDX_W-1:0]  raddr;
  logic              fifo_full;
  logic              fifo_empty;
  flags_t            flags;

  assign p_sel[DEV_PORT]    = dev_sel;
  assign p_we[DEV_PORT]     = dev_we;
  assign p_addr[DEV_PORT]   = dev_addr;
  assign p_wdata[DEV_PORT]  = dev_wdata;
  assign p_sel[HOST_PORT]   = host_sel;
  assign p_we[HOST_PORT]    = host_we;
  assign p_addr[HOST_PORT]  = host_addr;
  assign p_wdata[HOST_PORT] = host_wdata;

  assign dev_rvalid  = p_rvalid[DEV_PORT];
  assign dev_rdata   = p_rdata[DEV_PORT];
  assign host_rvalid = p_rvalid[HOST_PORT];
  assign host_rdata  = p_rdata[HOST_PORT];

  assign flags.full = fifo_full;
  assign flags.have = ~fifo_empty;

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    dmf_decode #(.ADDR_W(ADDR_W)) dec_i (
      .sel  (p_sel[g]),
      .we   (p_we[g]),
      .addr (p_addr[g]),
      .rd   (p_rd[g]),
      .push (push_req[g]),
      .pop  (pop_req[g]),
      .tgt  (p_tgt[g])
    );

    dmf_resp resp_i (
      .clk    (clk),
      .rst    (rst),
      .rd     (p_rd[g]),
      .tgt    (p_tgt[g]),
      .grant  (pop_grant[g]),
      .head   (head),
      .flags  (flags),
      .rvalid (p_rvalid[g]),
      .rdata  (p_rdata[g])
    );
  end

  dmf_arbiter #(.PORTS(PORTS)) arb_i (
    .push_req  (push_req),
    .pop_req   (pop_req),
    .wdata     (p_wdata),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .push_ok   (push_ok),
    .push_data (push_data),
    .pop_ok    (pop_ok),
    .pop_grant (pop_grant)
  );

  dmf_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk     (clk),
    .rst     (rst),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .waddr   (waddr),
    .raddr   (raddr),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  dmf_store #(.DEPTH(DEPTH), .W(BYTE_W)) store_i (
    .clk   (clk),
    .we    (push_ok),
    .waddr (waddr),
    .wdata (push_data),
    .raddr (raddr),
    .rdata (head)
  );

endmodule

// File: rtl/dmf_checker.sv
module dmf_checker
  import dmf_pkg::*;
#(
  parameter  int unsigned DEPTH  = 64,
  parameter  int unsigned ADDR_W = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              dev_sel,
  input logic              dev_we,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              dev_rvalid,
  input logic [7:0]        dev_rdata,
  input logic              host_sel,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rvalid,
  input logic [7:0]        host_rdata,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              push_ok,
  input logic              pop_ok
);

  logic [PTR_W-1:0] occ;
  logic             dev_ld;
  logic             host_ld;
  assign occ     = wr_ptr - rd_ptr;
  assign dev_ld  = dev_sel & ~dev_we;
  assign host_ld = host_sel & ~host_we;

  assert_dev_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    dev_ld |=> dev_rvalid);
  assert_dev_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !dev_ld |=> !dev_rvalid);
  assert_host_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    host_ld |=> host_rvalid);
  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH));
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (host_ld && host_addr == ADDR_W'(OFF_STAT)) |=> host_rdata[7:2] == 6'd0);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> $stable(wr_ptr));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |=> $stable(rd_ptr));
  assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (dev_ld && dev_addr == ADDR_W'(OFF_OUT) && fifo_empty) |=> dev_rdata == 8'h00);
  assert_balanced_occ_R7: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> occ == $past(occ));
  assert_host_loses_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (dev_ld && dev_addr == ADDR_W'(OFF_OUT) &&
     host_ld && host_addr == ADDR_W'(OFF_OUT)) |=> host_rdata == 8'h00);

endmodule

bind dbg_msg_fifo dmf_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .dev_sel     (dev_sel),
  .dev_we      (dev_we),
  .dev_addr    (dev_addr),
  .dev_rvalid  (dev_rvalid),
  .dev_rdata   (dev_rdata),
  .host_sel    (host_sel),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .push_ok     (push_ok),
  .pop_ok      (pop_ok)
);

// File: tb/dbg_msg_fifo_tb_top.sv
module dbg_msg_fifo_tb_top;

  localparam int DEPTH  = 64;
  localparam int ADDR_W = 4;
  localparam logic [3:0] A_IN = 4'h0, A_OUT = 4'h4, A_ST = 4'h8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic dev_sel = 0, dev_we = 0, host_sel = 0, host_we = 0;
  logic [ADDR_W-1:0] dev_addr = '0, host_addr = '0;
  logic [7:0] dev_wdata = '0, host_wdata = '0;
  logic dev_rvalid, host_rvalid;
  logic [7:0] dev_rdata, host_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dbg_msg_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .dev_sel(dev_sel), .dev_we(dev_we), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       port;   // 0 device, 1 host
    logic       we;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b1, 1'b0, 4'h8, 8'h00, 8'h00},  // R1 status after reset
    '{4'd6, 1'b1, 1'b0, 4'h4, 8'h00, 8'h00},  // R6 empty pop
    '{4'd3, 1'b0, 1'b1, 4'h0, 8'h41, 8'h00},  // R3 push
    '{4'd4, 1'b1, 1'b0, 4'h8, 8'h00, 8'h02},  // R4 have flag
    '{4'd3, 1'b0, 1'b1, 4'h0, 8'h42, 8'h00},
    '{4'd9, 1'b1, 1'b1, 4'h4, 8'h99, 8'h00},  // R9 store to data-out
    '{4'd9, 1'b1, 1'b1, 4'h8, 8'hFF, 8'h00},  // R9 store to status
    '{4'd9, 1'b0, 1'b1, 4'hC, 8'h77, 8'h00},  // R9 store unmapped
    '{4'd9, 1'b1, 1'b0, 4'h0, 8'h00, 8'h00},  // R9 load data-in
    '{4'd9, 1'b1, 1'b0, 4'hC, 8'h00, 8'h00},  // R9 load unmapped
    '{4'd3, 1'b1, 1'b0, 4'h4, 8'h00, 8'h41},  // R3 order
    '{4'd3, 1'b1, 1'b0, 4'h4, 8'h00, 8'h42},
    '{4'd4, 1'b1, 1'b0, 4'h8, 8'h00, 8'h00},  // R4 flags clear
    '{4'd6, 1'b1, 1'b0, 4'h4, 8'h00, 8'h00},  // R6 stray stores pushed nothing
    '{4'd3, 1'b1, 1'b1, 4'h0, 8'h55, 8'h00},  // R3 host pushes
    '{4'd2, 1'b0, 1'b0, 4'h4, 8'h00, 8'h55},  // R2 device pops
    '{4'd9, 1'b0, 1'b0, 4'h1, 8'h00, 8'h00}   // R9 misaligned offset
  };

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Drive both ports at a falling edge; results are readable at the next one.
  task automatic op2(input logic ds, dw, input logic [3:0] da, input logic [7:0] dd,
                     input logic hs, hw, input logic [3:0] ha, input logic [7:0] hd);
    dev_sel = ds;  dev_we = dw;  dev_addr = da;  dev_wdata = dd;
    host_sel = hs; host_we = hw; host_addr = ha; host_wdata = hd;
    @(negedge clk);
    dev_sel = 0; host_sel = 0;
  endtask

  task automatic op(input logic port, we, input logic [3:0] a, input logic [7:0] d);
    if (port) op2(0, 0, 0, 0, 1, we, a, d);
    else      op2(1, we, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic port, input logic [3:0] a, input logic [7:0] exp,
                    input string tag);
    op(port, 0, a, 8'h00);
    check(tag, "response strobe", {7'd0, port ? host_rvalid : dev_rvalid}, 8'h01);
    check(tag, "load data", port ? host_rdata : dev_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", "dev strobe in reset", {7'd0, dev_rvalid}, 8'h00);
    check("R1", "host strobe in reset", {7'd0, host_rvalid}, 8'h00);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      op(v.port, v.we, v.addr, v.wdata);
      check($sformatf("R%0d", v.req), $sformatf("vector %0d strobe", i),
            {7'd0, v.port ? host_rvalid : dev_rvalid}, {7'd0, !v.we});
      if (!v.we)
        check($sformatf("R%0d", v.req), $sformatf("vector %0d data", i),
              v.port ? host_rdata : dev_rdata, v.exp);
    end

    // R4/R5: fill to DEPTH, overflow store dropped, drain in order
    for (int i = 0; i < DEPTH; i++) op(0, 1, A_IN, 8'(i));
    rd(1, A_ST, 8'h03, "R4");
    op(0, 1, A_IN, 8'hEE);
    rd(1, A_ST, 8'h03, "R5");
    for (int i = 0; i < DEPTH; i++) rd(1, A_OUT, 8'(i), "R5");
    rd(1, A_ST, 8'h00, "R4");

    // R7: push and pop in one cycle with one byte held
    op(0, 1, A_IN, 8'h10);
    op2(1, 1, A_IN, 8'h20, 1, 0, A_OUT, 8'h00);
    check("R7", "pop during push", host_rdata, 8'h10);
    rd(1, A_ST, 8'h02, "R7");
    rd(1, A_OUT, 8'h20, "R7");
    rd(1, A_ST, 8'h00, "R7");

    // R7: same-cycle push and pop while empty
    op2(1, 1, A_IN, 8'h30, 1, 0, A_OUT, 8'h00);
    check("R7", "pop on empty during push", host_rdata, 8'h00);
    rd(1, A_OUT, 8'h30, "R7");

    // R7: same-cycle push and pop while full
    for (int i = 0; i < DEPTH; i++) op(0, 1, A_IN, 8'(i + 1));
    op2(1, 1, A_IN, 8'hEE, 1, 0, A_OUT, 8'h00);
    check("R7", "pop on full during push", host_rdata, 8'h01);
    rd(1, A_ST, 8'h02, "R7");
    for (int i = 1; i < DEPTH; i++) rd(1, A_OUT, 8'(i + 1), "R7");
    rd(1, A_OUT, 8'h00, "R7");

    // R8: both ports push, then both ports pop
    op2(1, 1, A_IN, 8'h61, 1, 1, A_IN, 8'h62);
    rd(1, A_OUT, 8'h61, "R8");
    rd(1, A_OUT, 8'h00, "R8");
    op(0, 1, A_IN, 8'h71);
    op(0, 1, A_IN, 8'h72);
    op2(1, 0, A_OUT, 8'h00, 1, 0, A_OUT, 8'h00);
    check("R8", "device wins pop", dev_rdata, 8'h71);
    check("R8", "host loses pop", host_rdata, 8'h00);
    rd(1, A_OUT, 8'h72, "R8");

    // R10: reset while holding bytes
    op(0, 1, A_IN, 8'hA1);
    op(0, 1, A_IN, 8'hA2);
    op(0, 1, A_IN, 8'hA3);
    rst = 1;
    @(negedge clk);
    rst = 0;
    rd(1, A_ST, 8'h00, "R10");
    rd(0, A_OUT, 8'h00, "R10");

    summary();
  end

endmodule